// File: doc/BRIEF.md
# Binary Tree Route Sequencer

This block turns a (source leaf, destination leaf) pair into the hop-by-hop path through a binary tree or fat-tree switch network with 2^ADDR_W leaves. Leaf addresses are binary vectors read from the root downward, so bit ADDR_W-1 picks the branch taken at the root and bit 0 picks the branch just above the leaf. The path climbs to the lowest common ancestor of the two leaves and then descends to the destination. Where a fat tree offers several parallel up-links, the consumer takes the lowest-indexed one; this block only says "up".

The height of the climb comes from the exclusive-or of the two addresses. If j is the index of its highest set bit, the route makes j+1 up hops and then j+1 down hops. The down hops read the destination bits from bit j down to bit 0. A requester offers one address pair per handshake. The block then streams one registered hop per clock and flags the final hop. It holds off further requests until that hop is on its outputs.

Top module: `tree_route_gen`

## Requirements
- R1: After synchronous reset, req_ready is 1 and hop_valid, hop_last and route_done are 0.
- R2: A route from src to a different dst begins with exactly j+1 hops of code 2'b00 (up), where j is the index of the highest set bit of src XOR dst. No up hop follows a down hop, and an up hop is never the last one.
- R3: After the up hops come exactly j+1 down hops. Down hop m (m = 0..j) looks at dst bit j-m: a 0 gives code 2'b01 (down-left) and a 1 gives code 2'b10 (down-right). Code 2'b11 never appears.
- R4: The first hop appears in the cycle after the accepting edge. hop_valid then stays high on every cycle until the last hop, one hop per cycle.
- R5: hop_last and route_done are both high in the cycle of the final hop and in no other hop cycle. A route has at most 2*ADDR_W hops.
- R6: When src equals dst, no hop is produced. route_done pulses for one cycle after the accepting edge, and req_ready stays high.
- R7: req_ready is low from the cycle after acceptance until the cycle that shows the last hop, where it returns high. A req_valid offered while req_ready is low is ignored: the current hop stream is unchanged and no extra hop follows it.
- R8: A request accepted during the last-hop cycle starts its first hop in the very next cycle, with no idle cycle between routes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_src | input | ADDR_W | Source leaf address |
| req_dst | input | ADDR_W | Destination leaf address |
| hop_valid | output | 1 | A hop is present this cycle |
| hop_dir | output | 2 | 00 up, 01 down-left, 10 down-right |
| hop_last | output | 1 | Final hop of the route |
| route_done | output | 1 | Route finished (with last hop, or alone for src equal to dst) |

## Verification
The assertions check the shape of every stream on every cycle. They confirm that no up hop follows a down hop, that the code 11 never appears, that last and done coincide, and that req_ready is low exactly while a non-final hop is shown. They also confirm that the stream has no gaps and that a route never grows beyond 2*ADDR_W hops. Only the bench scenarios can show that the number of up hops matches the highest differing bit and that each turn follows the right destination bit. The same holds for ignoring requests while busy, the lone done pulse for equal addresses, and back-to-back routes. The bench compares each of these against sequences it builds from the address pair.

// File: rtl/tree_route_pkg.sv
package tree_route_pkg;
  typedef enum logic [1:0] {
    HOP_UP       = 2'b00,
    HOP_DN_LEFT  = 2'b01,
    HOP_DN_RIGHT = 2'b10
  } hop_e;
endpackage

// File: rtl/route_plan.sv
// Combinational address arithmetic: relative address and climb height.
module route_plan #(
  parameter int ADDR_W = 4,
  parameter int IW     = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  output logic              same_leaf,
  output logic [IW-1:0]     top_idx
);
  logic [ADDR_W-1:0] rel;

  assign rel       = src ^ dst;
  assign same_leaf = (rel == '0);

  // highest set bit of the relative address; later iterations win
  always_comb begin
    top_idx = '0;
    for (int b = 0; b < ADDR_W; b++) begin
      if (rel[b]) top_idx = IW'(b);
    end
  end
endmodule

// File: rtl/hop_sequencer.sv
// Holds route state and computes the next hop to register.
module hop_sequencer
  import tree_route_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int IW     = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              same_leaf,
  input  logic [IW-1:0]     top_idx,
  input  logic [ADDR_W-1:0] dst,
  output logic              nxt_valid,
  output hop_e              nxt_dir,
  output logic              nxt_last,
  output logic              nxt_done,
  output logic              nxt_ready
);
  logic              busy_q, busy_n;
  logic [IW-1:0]     ups_q, ups_n;
  logic [IW-1:0]     pos_q, pos_n;
  logic [ADDR_W-1:0] dst_q, dst_n;

  always_comb begin
    nxt_valid = 1'b0;
    nxt_dir   = HOP_UP;
    nxt_last  = 1'b0;
    nxt_done  = 1'b0;
    busy_n    = busy_q;
    ups_n     = ups_q;
    pos_n     = pos_q;
    dst_n     = dst_q;
    if (!busy_q) begin
      if (accept) begin
        if (same_leaf) begin
          nxt_done = 1'b1;
        end else begin
          nxt_valid = 1'b1;
          nxt_dir   = HOP_UP;
          busy_n    = 1'b1;
          ups_n     = top_idx;   // one up hop is emitted now
          pos_n     = top_idx;
          dst_n     = dst;
        end
      end
    end else if (ups_q != '0) begin
      nxt_valid = 1'b1;
      nxt_dir   = HOP_UP;
      ups_n     = ups_q - 1'b1;
    end else begin
      nxt_valid = 1'b1;
      nxt_dir   = dst_q[pos_q] ? HOP_DN_RIGHT : HOP_DN_LEFT;
      if (pos_q == '0) begin
        nxt_last = 1'b1;
        nxt_done = 1'b1;
        busy_n   = 1'b0;
      end else begin
        pos_n = pos_q - 1'b1;
      end
    end
    nxt_ready = !busy_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ups_q  <= '0;
      pos_q  <= '0;
      dst_q  <= '0;
    end else begin
      busy_q <= busy_n;
      ups_q  <= ups_n;
      pos_q  <= pos_n;
      dst_q  <= dst_n;
    end
  end
endmodule

// File: rtl/hop_out_reg.sv
// Output register stage: every port of the top leaves from a flop.
module hop_out_reg
  import tree_route_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       d_valid,
  input  hop_e       d_dir,
  input  logic       d_last,
  input  logic       d_done,
  input  logic       d_ready,
  output logic       q_valid,
  output logic [1:0] q_dir,
  output logic       q_last,
  output logic       q_done,
  output logic       q_ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_dir   <= HOP_UP;
      q_last  <= 1'b0;
      q_done  <= 1'b0;
      q_ready <= 1'b1;
    end else begin
      q_valid <= d_valid;
      q_dir   <= d_dir;
      q_last  <= d_last;
      q_done  <= d_done;
      q_ready <= d_ready;
    end
  end
endmodule

// File: rtl/tree_route_gen.sv
module tree_route_gen
  import tree_route_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_src,
  input  logic [ADDR_W-1:0] req_dst,
  output logic              hop_valid,
  output logic [1:0]        hop_dir,
  output logic              hop_last,
  output logic              route_done
);
  localparam int IW = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;

  logic          accept;
  logic          same_leaf;
  logic [IW-1:0] top_idx;
  logic          n_valid, n_last, n_done, n_ready;
  hop_e          n_dir;

  assign accept = req_valid && req_ready;

  route_plan #(.ADDR_W(ADDR_W), .IW(IW)) u_plan (
    .src       (req_src),
    .dst       (req_dst),
    .same_leaf (same_leaf),
    .top_idx   (top_idx)
  );

  hop_sequencer #(.ADDR_W(ADDR_W), .IW(IW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .same_leaf (same_leaf),
    .top_idx   (top_idx),
    .dst       (req_dst),
    .nxt_valid (n_valid),
    .nxt_dir   (n_dir),
    .nxt_last  (n_last),
    .nxt_done  (n_done),
    .nxt_ready (n_ready)
  );

  hop_out_reg u_out (
    .clk     (clk),
    .rst     (rst),
    .d_valid (n_valid),
    .d_dir   (n_dir),
    .d_last  (n_last),
    .d_done  (n_done),
    .d_ready (n_ready),
    .q_valid (hop_valid),
    .q_dir   (hop_dir),
    .q_last  (hop_last),
    .q_done  (route_done),
    .q_ready (req_ready)
  );
endmodule

// File: rtl/tree_route_gen_chk.sv
module tree_route_gen_chk #(
  parameter int ADDR_W = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       req_ready,
  input logic       hop_valid,
  input logic [1:0] hop_dir,
  input logic       hop_last,
  input logic       route_done
);
  localparam int MAXH = 2 * ADDR_W;
  localparam int CW   = $clog2(MAXH + 1) + 1;

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || (hop_valid && hop_last)) run_cnt <= '0;
    else if (hop_valid)                 run_cnt <= run_cnt + 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !hop_valid && !route_done));

  // R2
  up_not_last_chk: assert property (@(posedge clk) disable iff (rst)
    (hop_valid && hop_dir == 2'b00) |-> !hop_last);

  // R2
  no_up_after_down_chk: assert property (@(posedge clk) disable iff (rst)
    (hop_valid && hop_dir != 2'b00 && !hop_last) |=> (hop_valid && hop_dir != 2'b00));

  // R3
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    hop_valid |-> (hop_dir != 2'b11));

  // R4
  no_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (hop_valid && !hop_last) |=> hop_valid);

  // R5
  last_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    hop_valid |-> (hop_last == route_done));

  // R5
  hop_bound_chk: assert property (@(posedge clk) disable iff (rst)
    hop_valid |-> (run_cnt < CW'(MAXH)));

  // R6
  lone_done_chk: assert property (@(posedge clk) disable iff (rst)
    (route_done && !hop_valid) |-> req_ready);

  // R7
  ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> (hop_valid && !hop_last));

  // R7
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (hop_valid && !hop_last) |-> !req_ready);
endmodule

bind tree_route_gen tree_route_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .hop_valid  (hop_valid),
  .hop_dir    (hop_dir),
  .hop_last   (hop_last),
  .route_done (route_done)
);

// File: tb/sim_tree_route_gen.sv
`timescale 1ns/1ps
module sim_tree_route_gen;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [W-1:0] req_src = '0;
  logic [W-1:0] req_dst = '0;
  logic         hop_valid;
  logic [1:0]   hop_dir;
  logic         hop_last;
  logic         route_done;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  tree_route_gen #(.ADDR_W(W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .hop_valid(hop_valid),
    .hop_dir(hop_dir), .hop_last(hop_last), .route_done(route_done)
  );

  function automatic int top_bit(input logic [W-1:0] x);
    int r = -1;
    for (int b = 0; b < W; b++) if (x[b]) r = b;
    return r;
  endfunction

  function automatic logic [1:0] want_dir(input logic [W-1:0] s, input logic [W-1:0] d, input int k);
    int n = top_bit(s ^ d) + 1;
    if (k < n) return 2'b00;
    return d[n - 1 - (k - n)] ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Called at the negedge after the accepting edge. On the last hop either
  // drops req_valid or offers the chained request (cs, cd).
  task automatic check_stream(input logic [W-1:0] s, input logic [W-1:0] d,
                              input bit noise, input bit chain,
                              input logic [W-1:0] cs, input logic [W-1:0] cd);
    int n;
    if (s == d) begin
      chk(route_done == 1'b1, "R6 done", route_done, 1);
      chk(hop_valid == 1'b0, "R6 no hop", hop_valid, 0);
      chk(req_ready == 1'b1, "R6 ready", req_ready, 1);
      req_valid = chain;
      req_src = cs; req_dst = cd;
      return;
    end
    n = top_bit(s ^ d) + 1;
    for (int k = 0; k < 2 * n; k++) begin
      bit lst = (k == 2 * n - 1);
      chk(hop_valid == 1'b1, (k < n) ? "R2 valid" : "R4 valid", hop_valid, 1);
      chk(hop_dir == want_dir(s, d, k), (k < n) ? "R2 dir" : "R3 dir",
          hop_dir, want_dir(s, d, k));
      chk(hop_last == lst, "R5 last", hop_last, lst);
      chk(route_done == lst, "R5 done", route_done, lst);
      chk(req_ready == lst, "R7 ready", req_ready, lst);
      if (lst) begin
        req_valid = chain;
        req_src = cs; req_dst = cd;
      end else begin
        if (noise) begin
          req_valid = 1'b1;
          req_src = W'($urandom);
          req_dst = W'($urandom);
        end else begin
          req_valid = 1'b0;
        end
        @(negedge clk);
      end
    end
  endtask

  task automatic check_idle(input string req);
    @(negedge clk);
    chk(hop_valid == 1'b0, req, hop_valid, 0);
    chk(route_done == 1'b0, req, route_done, 0);
    chk(req_ready == 1'b1, req, req_ready, 1);
  endtask

  task automatic run(input logic [W-1:0] s, input logic [W-1:0] d, input bit noise);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_src = s; req_dst = d;
    @(negedge clk);
    req_valid = 1'b0;
    check_stream(s, d, noise, 1'b0, '0, '0);
    check_idle(noise ? "R7 ignored" : "R4 idle");
  endtask

  initial begin
    void'($urandom(32'd4021));
    repeat (3) @(negedge clk);
    // R1 reset state while reset held
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(hop_valid == 1'b0, "R1 valid", hop_valid, 0);
    chk(route_done == 1'b0, "R1 done", route_done, 0);
    rst = 1'b0;

    run(4'd6, 4'd6, 1'b0);    // R6 equal leaves
    run(4'd0, 4'd1, 1'b0);    // R2 shortest climb
    run(4'd0, 4'd15, 1'b0);   // R5 longest route, 2*W hops
    run(4'd15, 4'd0, 1'b1);   // R7 ignored requests while busy
    run(4'd5, 4'd4, 1'b0);    // R3 down-left only
    run(4'd9, 4'd11, 1'b1);   // R3 down-right then

    // R8 back-to-back routes
    @(negedge clk);
    req_valid = 1'b1; req_src = 4'd3; req_dst = 4'd12;
    @(negedge clk);
    req_valid = 1'b0;
    check_stream(4'd3, 4'd12, 1'b0, 1'b1, 4'd7, 4'd6);
    @(negedge clk);
    req_valid = 1'b0;
    chk(hop_valid == 1'b1, "R8 immediate start", hop_valid, 1);
    check_stream(4'd7, 4'd6, 1'b0, 1'b0, '0, '0);
    check_idle("R8 idle");

    for (int t = 0; t < 80; t++) begin
      logic [W-1:0] s = W'($urandom);
      logic [W-1:0] d = ($urandom % 8 == 0) ? s : W'($urandom);
      run(s, d, bit'($urandom % 2));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule